// File: doc/BRIEF.md
# Debug Trigger Security Gate

This block sits between a hart's trigger match logic and the logic that enters Debug Mode, raises traps or drives external trigger pins. Each cycle it takes the raw per-trigger hits, the action code and enabled-privilege mask of each trigger, and the hart's privilege state. From these it decides which hits may take effect.

A hit that asks to enter Debug Mode, or to pulse an external trigger output, passes only while debugging is allowed at the current privilege. Such a Debug-Mode request is held back while the hart is between a privilege change and its trap handler. Hits with any other action pass through untouched.

The gate also judges register writes to the triggers. It refuses a write that touches the trigger-mode bit from a context without the right to change it. It refuses any write to a member of a linked group of triggers whose highest enabled privilege lies above the debug ceiling. A refused write is dropped and reported with a one-cycle error pulse.

Top module: `dbg_trig_gate`

## Requirements
- R1: Debug is allowed when `mach_dbg_en` is 1 or when `cur_priv` (U=0, S=1, M=3) is numerically less than or equal to `priv_ceiling`. A trigger with action code 1 (enter Debug Mode) and an effective hit drives its `dbg_fire` bit in the same cycle only while debug is allowed.
- R2: A trigger's effective hit is `trig_hit[i]` OR (`trig_ext_src[i]` AND `ext_trig_in`). A trigger with action 1 that is hit only through `ext_trig_in` fires under the same debug-allowed rule as R1.
- R3: `ext_trig_out[0]` is the OR of effective hits of triggers with action code 8, and `ext_trig_out[1]` is the same for action 9. Both are forced to 0 while debug is not allowed.
- R4: For every action code other than 1, 8 and 9 (including 0, breakpoint exception), `fire_out[i]` equals the effective hit regardless of privilege. For codes 1, 8 and 9, `fire_out[i]` stays 0.
- R5: A write request with `wr_dmode`=1 is granted only if `in_debug` is 1, or if `mach_dbg_en` is 0 and `cur_priv` is M (3). Otherwise it is refused.
- R6: `trig_link[i]`=1 joins trigger i and trigger i+1 into one group. The privilege mask has one bit per level: bit 0 U, bit 1 S, bit 2 M. The group's privilege is the highest level enabled by any member. `chain_lock[i]` is 1 when trigger i belongs to a group of two or more, `mach_dbg_en` is 0, and the group privilege exceeds `priv_ceiling`.
- R7: A write request is granted on `wr_grant` one cycle after it is presented, when it is neither locked (R6) nor refused (R5). If any presented request is refused, `wr_err` is 1 for exactly the next cycle. A refused bit never appears on `wr_grant`.
- R8: While `trap_window` is 1, `dbg_fire` is 0, and every action-1 hit is held pending.
- R9: In the first cycle after `trap_window` returns to 0, held requests appear on `dbg_fire` (together with live action-1 hits) if debug is allowed in that cycle. Otherwise they are discarded, and they never appear later.
- R10: While `rst_n` is 0 and after reset, `wr_grant`, `wr_err` and the held requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_priv | input | 2 | Current hart privilege (U=0, S=1, M=3) |
| priv_ceiling | input | 2 | Highest privilege at which debugging is allowed |
| mach_dbg_en | input | 1 | Machine-level debug enable; 1 allows debug at every level |
| in_debug | input | 1 | Hart is in Debug Mode |
| trap_window | input | 1 | Privilege change or PC redirect in progress |
| trig_hit | input | N_TRIG | Raw per-trigger hit |
| trig_action | input | 4*N_TRIG | Per-trigger action code, 4 bits each |
| trig_privmask | input | 3*N_TRIG | Per-trigger enabled privileges (bit0 U, bit1 S, bit2 M) |
| trig_link | input | N_TRIG-1 | Bit i links trigger i with trigger i+1 |
| trig_ext_src | input | N_TRIG | Trigger also hit by the external trigger input |
| ext_trig_in | input | 1 | External trigger input |
| wr_req | input | N_TRIG | Per-trigger register write request |
| wr_dmode | input | 1 | The write changes the trigger-mode bit |
| fire_out | output | N_TRIG | Hits passed through for non-gated actions |
| dbg_fire | output | N_TRIG | Permitted Debug-Mode entry request |
| ext_trig_out | output | 2 | Gated external trigger outputs (actions 8, 9) |
| chain_lock | output | N_TRIG | Trigger belongs to a locked group |
| wr_grant | output | N_TRIG | Write accepted (registered) |
| wr_err | output | 1 | A write was dropped (registered pulse) |

## Verification
The bench goes after the privilege boundary, with the current level equal to, and one above, the ceiling. A gate that compares with the wrong sense or strictness would fire Debug-Mode entry or external pins one level too high or too low.

It holds a Debug-Mode hit across a multi-cycle trap window and then releases it once with debug allowed and once with debug revoked. A design without a hold register would lose the request. A design that forgets to clear it would fire late.

Groups are built with mixed masks, a mask with only the U bit, and a lone high-privilege trigger. A design that scans the wrong direction, ignores group size or takes the lowest level would lock the wrong triggers. Trigger-mode writes from M-mode with the enable bit set, and the one-cycle shape of the error pulse, are checked as well.

// File: rtl/dtg_pkg.sv
// Shared constants for the debug trigger security gate.
// Assumes the two-bit privilege encoding U=0, S=1, M=3.
package dtg_pkg;
    localparam int ACT_W  = 4;
    localparam int MASK_W = 3;

    localparam logic [ACT_W-1:0] ACT_DBG  = 4'd1;
    localparam logic [ACT_W-1:0] ACT_EXT0 = 4'd8;
    localparam logic [ACT_W-1:0] ACT_EXT1 = 4'd9;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    // Mask bits (bit0 U, bit1 S, bit2 M) of levels strictly above a ceiling.
    function automatic logic [MASK_W-1:0] levels_above(input logic [1:0] ceil);
        logic [MASK_W-1:0] r;
        r[0] = 1'b0;
        r[1] = (ceil < 2'(PRIV_S));
        r[2] = (ceil < 2'(PRIV_M));
        return r;
    endfunction
endpackage

// File: rtl/dtg_allow.sv
// Debug permission decision from the hart privilege state.
// Assumes priv_ceiling uses the same numeric encoding as cur_priv.
module dtg_allow (
    input  logic [1:0] cur_priv,
    input  logic [1:0] priv_ceiling,
    input  logic       mach_dbg_en,
    output logic       allowed
);
    // Debug is open at every level when machine debug is enabled.
    always_comb begin
        allowed = mach_dbg_en | (cur_priv <= priv_ceiling);
    end
endmodule

// File: rtl/dtg_chain.sv
// Group privilege scan and lock flag per trigger.
// Assumes link bit i joins trigger i with trigger i+1 and N_TRIG >= 2.
module dtg_chain
    import dtg_pkg::*;
#(
    parameter int N_TRIG = 4
) (
    input  logic [N_TRIG-2:0]        trig_link,
    input  logic [N_TRIG*MASK_W-1:0] trig_privmask,
    input  logic [1:0]               priv_ceiling,
    input  logic                     mach_dbg_en,
    output logic [N_TRIG-1:0]        chain_lock
);
    logic [MASK_W-1:0] mask_a [N_TRIG];
    logic [N_TRIG-1:0] link_lo;
    logic [N_TRIG-1:0] link_hi;
    logic [MASK_W-1:0] above;

    assign link_lo = {trig_link, 1'b0};
    assign link_hi = {1'b0, trig_link};
    assign above   = levels_above(priv_ceiling);

    for (genvar gi = 0; gi < N_TRIG; gi++) begin : g_trig
        logic [MASK_W-1:0] grp;
        logic              dn;
        logic              up;

        assign mask_a[gi] = trig_privmask[gi*MASK_W +: MASK_W];

        // Collect enabled levels along the linked run below and above this trigger.
        always_comb begin
            grp = mask_a[gi];
            dn  = 1'b1;
            for (int j = gi - 1; j >= 0; j--) begin
                dn = dn & link_hi[j];
                if (dn) grp = grp | mask_a[j];
            end
            up = 1'b1;
            for (int j = gi; j < N_TRIG - 1; j++) begin
                up = up & link_hi[j];
                if (up) grp = grp | mask_a[j+1];
            end
        end

        // Lock only real groups whose top level lies above the ceiling.
        always_comb begin
            chain_lock[gi] = (link_lo[gi] | link_hi[gi]) & ~mach_dbg_en & (|(grp & above));
        end
    end
endmodule

// File: rtl/dtg_hold.sv
// Holds Debug-Mode requests across a trap transition window.
// Assumes live_req already carries only action-1 effective hits.
module dtg_hold #(
    parameter int N_TRIG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_window,
    input  logic              allowed,
    input  logic [N_TRIG-1:0] live_req,
    output logic [N_TRIG-1:0] dbg_fire
);
    logic [N_TRIG-1:0] pend_q;

    // Accumulate during the window; drop everything once it closes.
    always_ff @(posedge clk) begin
        if (!rst_n)           pend_q <= '0;
        else if (trap_window) pend_q <= pend_q | live_req;
        else                  pend_q <= '0;
    end

    // Issue live and held requests only outside the window with permission.
    always_comb begin
        dbg_fire = (trap_window | ~allowed) ? '0 : (live_req | pend_q);
    end
endmodule

// File: rtl/dbg_trig_gate.sv
// Top of the debug trigger security gate: gates fires, external pins and writes.
// Assumes all inputs are synchronous to clk; write verdicts appear one cycle later.
module dbg_trig_gate
    import dtg_pkg::*;
#(
    parameter int N_TRIG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cur_priv,
    input  logic [1:0]               priv_ceiling,
    input  logic                     mach_dbg_en,
    input  logic                     in_debug,
    input  logic                     trap_window,
    input  logic [N_TRIG-1:0]        trig_hit,
    input  logic [N_TRIG*ACT_W-1:0]  trig_action,
    input  logic [N_TRIG*MASK_W-1:0] trig_privmask,
    input  logic [N_TRIG-2:0]        trig_link,
    input  logic [N_TRIG-1:0]        trig_ext_src,
    input  logic                     ext_trig_in,
    input  logic [N_TRIG-1:0]        wr_req,
    input  logic                     wr_dmode,
    output logic [N_TRIG-1:0]        fire_out,
    output logic [N_TRIG-1:0]        dbg_fire,
    output logic [1:0]               ext_trig_out,
    output logic [N_TRIG-1:0]        chain_lock,
    output logic [N_TRIG-1:0]        wr_grant,
    output logic                     wr_err
);
    logic              allowed;
    logic [N_TRIG-1:0] heff;
    logic [N_TRIG-1:0] is_dbg;
    logic [N_TRIG-1:0] is_x0;
    logic [N_TRIG-1:0] is_x1;
    logic [N_TRIG-1:0] permit;
    logic              dmode_ok;

    assign heff = trig_hit | (trig_ext_src & {N_TRIG{ext_trig_in}});

    for (genvar gi = 0; gi < N_TRIG; gi++) begin : g_dec
        logic [ACT_W-1:0] act;
        assign act = trig_action[gi*ACT_W +: ACT_W];
        // Classify the action and pass through the ungated kinds.
        always_comb begin
            is_dbg[gi]   = (act == ACT_DBG);
            is_x0[gi]    = (act == ACT_EXT0);
            is_x1[gi]    = (act == ACT_EXT1);
            fire_out[gi] = heff[gi] & ~(is_dbg[gi] | is_x0[gi] | is_x1[gi]);
        end
    end

    dtg_allow u_allow (
        .cur_priv     (cur_priv),
        .priv_ceiling (priv_ceiling),
        .mach_dbg_en  (mach_dbg_en),
        .allowed      (allowed)
    );

    dtg_hold #(.N_TRIG(N_TRIG)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_window (trap_window),
        .allowed     (allowed),
        .live_req    (heff & is_dbg),
        .dbg_fire    (dbg_fire)
    );

    dtg_chain #(.N_TRIG(N_TRIG)) u_chain (
        .trig_link     (trig_link),
        .trig_privmask (trig_privmask),
        .priv_ceiling  (priv_ceiling),
        .mach_dbg_en   (mach_dbg_en),
        .chain_lock    (chain_lock)
    );

    // External pins follow their action codes only while debug is allowed.
    always_comb begin
        ext_trig_out[0] = allowed & (|(heff & is_x0));
        ext_trig_out[1] = allowed & (|(heff & is_x1));
    end

    // Write permission: group lock plus trigger-mode bit ownership.
    always_comb begin
        dmode_ok = in_debug | (~mach_dbg_en & (cur_priv == 2'(PRIV_M)));
        permit   = ~chain_lock & {N_TRIG{~wr_dmode | dmode_ok}};
    end

    // Register the write verdicts for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_grant <= '0;
            wr_err   <= 1'b0;
        end else begin
            wr_grant <= wr_req & permit;
            wr_err   <= |(wr_req & ~permit);
        end
    end
endmodule

// File: rtl/dtg_checker.sv
// Property checker for dbg_trig_gate, attached by bind below.
module dtg_checker #(
    parameter int N_TRIG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cur_priv,
    input logic [1:0]        priv_ceiling,
    input logic              mach_dbg_en,
    input logic              in_debug,
    input logic              trap_window,
    input logic [N_TRIG-1:0] trig_hit,
    input logic [N_TRIG-1:0] trig_ext_src,
    input logic              ext_trig_in,
    input logic [N_TRIG-1:0] wr_req,
    input logic              wr_dmode,
    input logic [N_TRIG-1:0] fire_out,
    input logic [N_TRIG-1:0] dbg_fire,
    input logic [1:0]        ext_trig_out,
    input logic [N_TRIG-1:0] chain_lock,
    input logic [N_TRIG-1:0] wr_grant,
    input logic              wr_err
);
    logic ok_now;
    assign ok_now = mach_dbg_en || (cur_priv <= priv_ceiling);

    AST_ENTRY_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|dbg_fire) |-> ok_now);                                                  // R1
    AST_PINS_NEED_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_trig_out) |-> ok_now);                                              // R3
    AST_PASS_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_out & ~(trig_hit | (trig_ext_src & {N_TRIG{ext_trig_in}}))) == '0); // R4
    AST_DMODE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_req) && wr_dmode && !in_debug && !(!mach_dbg_en && cur_priv == 2'd3))
        |=> (wr_grant == '0) && wr_err);                                          // R5
    AST_LOCKED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wr_req & chain_lock)) |=> wr_err && ((wr_grant & $past(wr_req & chain_lock)) == '0)); // R7
    AST_NO_ENTRY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        trap_window |-> (dbg_fire == '0));                                        // R8
endmodule

bind dbg_trig_gate dtg_checker #(.N_TRIG(N_TRIG)) u_dtg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_priv     (cur_priv),
    .priv_ceiling (priv_ceiling),
    .mach_dbg_en  (mach_dbg_en),
    .in_debug     (in_debug),
    .trap_window  (trap_window),
    .trig_hit     (trig_hit),
    .trig_ext_src (trig_ext_src),
    .ext_trig_in  (ext_trig_in),
    .wr_req       (wr_req),
    .wr_dmode     (wr_dmode),
    .fire_out     (fire_out),
    .dbg_fire     (dbg_fire),
    .ext_trig_out (ext_trig_out),
    .chain_lock   (chain_lock),
    .wr_grant     (wr_grant),
    .wr_err       (wr_err)
);

// File: tb/dbg_trig_gate_test.sv
// Scoreboard bench: the driver applies a vector at the falling edge and queues
// the expected outputs; the monitor compares them before and after the next edge.
`timescale 1ns/100ps
module dbg_trig_gate_test;
    localparam int N = 4;

    typedef struct {
        string      tag;
        logic [3:0] fire;
        logic [3:0] dbg;
        logic [1:0] ext;
        logic [3:0] lock;
        logic [3:0] grant;
        logic       err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_priv = '0, priv_ceiling = '0;
    logic        mach_dbg_en = 1'b0, in_debug = 1'b0, trap_window = 1'b0;
    logic [3:0]  trig_hit = '0, trig_ext_src = '0, wr_req = '0;
    logic [15:0] trig_action = '0;
    logic [11:0] trig_privmask = '0;
    logic [2:0]  trig_link = '0;
    logic        ext_trig_in = 1'b0, wr_dmode = 1'b0;
    logic [3:0]  fire_out, dbg_fire, chain_lock, wr_grant;
    logic [1:0]  ext_trig_out;
    logic        wr_err;

    // staged inputs, copied to the design at a falling edge
    logic [1:0]  s_cp = '0, s_ceil = '0;
    logic        s_mde = 1'b0, s_dbg = 1'b0, s_win = 1'b0, s_xin = 1'b0, s_wdm = 1'b0;
    logic [3:0]  s_hit = '0, s_xsrc = '0, s_req = '0;
    logic [15:0] s_act = '0;
    logic [11:0] s_mask = '0;
    logic [2:0]  s_link = '0;

    int   n_chk = 0, n_bad = 0;
    exp_t sb[$];
    logic [3:0] m_pend = '0;

    always #2.5 clk = ~clk;

    dbg_trig_gate #(.N_TRIG(N)) uut (.*);

    task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
        end
    endtask

    // Reference model from the requirements; pushes one expected item.
    task automatic push(string tag);
        exp_t e;
        logic ok, dok, x0, x1;
        logic [3:0] heff, live1, permit;
        logic [2:0] gm [4];
        int gs [4];
        int gid [4];
        int g, hp;
        ok   = mach_dbg_en || (cur_priv <= priv_ceiling);
        heff = trig_hit | (trig_ext_src & {4{ext_trig_in}});
        e.tag = tag; e.fire = '0; live1 = '0; x0 = 0; x1 = 0;
        for (int i = 0; i < 4; i++) begin
            case (trig_action[i*4 +: 4])
                4'd1:    live1[i] = heff[i];
                4'd8:    x0 = x0 | heff[i];
                4'd9:    x1 = x1 | heff[i];
                default: e.fire[i] = heff[i];
            endcase
        end
        e.ext = ok ? {x1, x0} : 2'b00;
        e.dbg = (!trap_window && ok) ? (live1 | m_pend) : 4'b0;
        m_pend = trap_window ? (m_pend | live1) : 4'b0;
        g = 0;
        for (int i = 0; i < 4; i++) begin gm[i] = '0; gs[i] = 0; end
        for (int i = 0; i < 4; i++) begin
            if (i > 0 && !trig_link[i-1]) g++;
            gid[i] = g;
            gm[g] = gm[g] | trig_privmask[i*3 +: 3];
            gs[g]++;
        end
        for (int i = 0; i < 4; i++) begin
            hp = gm[gid[i]][2] ? 3 : (gm[gid[i]][1] ? 1 : 0);
            e.lock[i] = (gs[gid[i]] >= 2) && !mach_dbg_en && (hp > int'(priv_ceiling));
        end
        dok    = in_debug || (!mach_dbg_en && cur_priv == 2'd3);
        permit = ~e.lock & ((wr_dmode && !dok) ? 4'b0 : 4'hF);
        e.grant = wr_req & permit;
        e.err   = |(wr_req & ~permit);
        sb.push_back(e);
    endtask

    task automatic step(string tag);
        @(negedge clk);
        cur_priv = s_cp; priv_ceiling = s_ceil; mach_dbg_en = s_mde; in_debug = s_dbg;
        trap_window = s_win; trig_hit = s_hit; trig_action = s_act; trig_privmask = s_mask;
        trig_link = s_link; trig_ext_src = s_xsrc; ext_trig_in = s_xin;
        wr_req = s_req; wr_dmode = s_wdm;
        push(tag);
    endtask

    // Monitor: combinational outputs just before the edge, registered ones after it.
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk(it.tag, "fire_out", 8'(fire_out), 8'(it.fire));
                chk(it.tag, "dbg_fire", 8'(dbg_fire), 8'(it.dbg));
                chk(it.tag, "ext_trig_out", 8'(ext_trig_out), 8'(it.ext));
                chk(it.tag, "chain_lock", 8'(chain_lock), 8'(it.lock));
                @(posedge clk);
                #1;
                chk(it.tag, "wr_grant", 8'(wr_grant), 8'(it.grant));
                chk(it.tag, "wr_err", 8'(wr_err), 8'(it.err));
            end
        end
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "wr_grant in reset", 8'(wr_grant), 8'd0);
        chk("R10", "wr_err in reset", 8'(wr_err), 8'd0);
        @(negedge clk); rst_n = 1'b1;
        step("R10");
        // R4 and R3: actions 0,5,8,9 all hit, M above ceiling U
        s_act = {4'd9, 4'd8, 4'd5, 4'd0}; s_hit = 4'hF; s_cp = 2'd3; s_ceil = 2'd0;
        step("R4");
        s_cp = 2'd0; s_ceil = 2'd1; step("R3");
        s_cp = 2'd3; s_ceil = 2'd1; s_mde = 1'b1; step("R3");
        // R1: action 1 on trigger 0 at and above the ceiling
        s_mde = 1'b0; s_act = {4'd0, 4'd0, 4'd0, 4'd1}; s_hit = 4'b0001;
        s_cp = 2'd1; s_ceil = 2'd1; step("R1");
        s_cp = 2'd3; step("R1");
        s_mde = 1'b1; step("R1");
        // R2: trigger 1 hit only through the external input
        s_mde = 1'b0; s_act = {4'd0, 4'd0, 4'd1, 4'd0}; s_hit = '0; s_xsrc = 4'b0010; s_xin = 1'b1;
        s_cp = 2'd0; step("R2");
        s_cp = 2'd3; step("R2");
        s_xsrc = '0; s_xin = 1'b0;
        // R8 and R9: hold across the window, release with permission
        s_act = {4'd0, 4'd0, 4'd0, 4'd1}; s_cp = 2'd1; s_ceil = 2'd1;
        s_win = 1'b1; s_hit = 4'b0001; step("R8");
        s_hit = '0; step("R8");
        s_win = 1'b0; step("R9");
        step("R9");
        // R9: release with permission revoked is discarded
        s_win = 1'b1; s_hit = 4'b0001; step("R8");
        s_hit = '0; s_win = 1'b0; s_cp = 2'd3; step("R9");
        s_cp = 2'd1; step("R9");
        // R6: groups and their privilege
        s_act = '0; s_link = 3'b011; s_mask = {3'b001, 3'b100, 3'b010, 3'b001};
        s_ceil = 2'd1; step("R6");
        s_ceil = 2'd3; step("R6");
        s_link = 3'b001; s_mask = {3'b100, 3'b001, 3'b010, 3'b001}; s_ceil = 2'd0; step("R6");
        s_mask = {3'b100, 3'b001, 3'b001, 3'b001}; step("R6");
        s_mde = 1'b1; s_mask = {3'b100, 3'b001, 3'b010, 3'b001}; step("R6");
        // R7: locked writes dropped with a one-cycle error
        s_mde = 1'b0; s_link = 3'b011; s_mask = {3'b001, 3'b100, 3'b010, 3'b001}; s_ceil = 2'd1;
        s_req = 4'b0101; step("R7");
        s_req = 4'b1000; step("R7");
        s_req = '0; step("R7");
        // R5: trigger-mode bit ownership
        s_link = '0; s_req = 4'b0001; s_wdm = 1'b1; s_dbg = 1'b1; s_cp = 2'd0; step("R5");
        s_dbg = 1'b0; s_cp = 2'd3; step("R5");
        s_mde = 1'b1; step("R5");
        s_mde = 1'b0; s_cp = 2'd1; step("R5");
        s_wdm = 1'b0; step("R5");
        s_req = '0; step("R7");
        repeat (4) @(posedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule